// File: doc/BRIEF.md
# Per-Bank SEC-DED Fuse Decoder

This block checks and repairs the contents of a set of one-time-programmable fuse banks before those contents are used as a power-up configuration. Each bank stores 20 data bits and 6 check bits. When a bank has error correction turned on, the decoder computes a 6-bit syndrome for it. From the syndrome it repairs a single wrong bit, or it reports an uncorrectable pattern and does not touch the data. A bank with correction turned off passes its raw bits straight through.

A load strobe captures the corrected data and the syndromes of all banks in one clock edge. The same edge sets a sticky single-error or double-error flag for each bank that shows a problem. Software clears these flags by writing 1 to them. Any flag that is set drives a common interrupt line. This interrupt is masked after reset until it is explicitly unmasked.

A separate combinational generator produces the 6 check bits for any 20-bit data word, so the word to be programmed can be prepared in advance.

Top module: `fuse_secded_dec`

## Requirements
- R1: The code assigns a column to each bit. Data bit i (i = 0..19) gets the i-th 6-bit value, counting from 0 in ascending numeric order, among the values that have exactly three ones. So data bit 0 maps to 0x07 and data bit 5 maps to 0x15. Check bit j gets the column 1<<j. The generator output `gen_chk` bit j is the XOR of the `gen_data` bits whose column has bit j set.
- R2: `dout`, `syn` and the newly set flags are taken from the fuse inputs on the rising edge where `load` is 1. They keep their values while `load` is 0. Bank b uses `fuse_data[b*20 +: 20]`, `fuse_chk[b*6 +: 6]`, `ecc_en[b]`, `dout[b*20 +: 20]` and `syn[b*6 +: 6]`.
- R3: The syndrome is the generated check bits of the stored data XORed with the stored check bits. For an enabled bank with a zero syndrome, the data is output unchanged and no flag is set.
- R4: A single wrong data bit in an enabled bank is corrected. The syndrome equals that bit's column (0x15 for data bit 5), and the bank's single-error flag is set.
- R5: A single wrong check bit j in an enabled bank leaves the data unchanged. It gives the syndrome 1<<j and sets the single-error flag.
- R6: A non-zero syndrome of even weight, or of weight above 3, sets the bank's double-error flag. In that case the raw data is output uncorrected. Two wrong bits always fall in this case.
- R7: For a bank with `ecc_en` low, the output is the raw data, the syndrome is 0 and no flag is set, whatever the check bits hold.
- R8: Error flags stay set until a 1 is written to `clr_se`/`clr_de` for that bank. A flag being set in the same cycle as its clear wins over the clear. A clear affects only its own bank and its own kind of flag.
- R9: `irq` is 1 when any flag of any bank is set and the mask is 0. The mask resets to 1 and takes `irq_mask_d` on an edge with `irq_mask_we` high.
- R10: After reset, `dout`, `syn`, all flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture decoded banks on this edge |
| ecc_en | input | NB | Per-bank correction enable |
| fuse_data | input | NB*DW | Raw data bits of all banks |
| fuse_chk | input | NB*CW | Stored check bits of all banks |
| clr_se | input | NB | Write-1 clear of single-error flags |
| clr_de | input | NB | Write-1 clear of double-error flags |
| irq_mask_we | input | 1 | Mask write strobe |
| irq_mask_d | input | 1 | New mask value (1 = masked) |
| gen_data | input | DW | Data word for check-bit generation |
| gen_chk | output | CW | Check bits for `gen_data` |
| dout | output | NB*DW | Corrected (or raw) data of all banks |
| syn | output | NB*CW | Captured syndromes |
| se_flag | output | NB | Sticky single-error flags |
| de_flag | output | NB | Sticky double-error flags |
| irq | output | 1 | Masked error interrupt |

## Verification
A wrong column assignment or a faulty syndrome would show up on the edge right after the `load` strobe. It would appear as a corrected bit in the wrong place, a syndrome that is not the flipped bit's column, or the wrong flag. The bench therefore flips chosen fuse bits and checks `dout`, `syn` and both flags one cycle after the strobe. A fault in flag stickiness or in the mask only shows once a later clear, load or mask write has run. So the bench also checks the flags and `irq` across sequences that mix clears, loads and mask writes.

// File: rtl/fuse_secded_dec.sv
module fuse_secded_dec #(
  parameter int NB = 10,
  parameter int DW = 20,
  parameter int CW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NB-1:0]    ecc_en,
  input  logic [NB*DW-1:0] fuse_data,
  input  logic [NB*CW-1:0] fuse_chk,
  input  logic [NB-1:0]    clr_se,
  input  logic [NB-1:0]    clr_de,
  input  logic             irq_mask_we,
  input  logic             irq_mask_d,
  input  logic [DW-1:0]    gen_data,
  output logic [CW-1:0]    gen_chk,
  output logic [NB*DW-1:0] dout,
  output logic [NB*CW-1:0] syn,
  output logic [NB-1:0]    se_flag,
  output logic [NB-1:0]    de_flag,
  output logic             irq
);

  function automatic logic [CW-1:0] col_code(input int k);
    int n;
    col_code = '0;
    n = 0;
    for (int v = 0; v < (1 << CW); v++) begin
      if ($countones(v[CW-1:0]) == 3) begin
        if (n == k) col_code = v[CW-1:0];
        n++;
      end
    end
  endfunction

  function automatic logic [CW-1:0] chk_of(input logic [DW-1:0] d);
    chk_of = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) chk_of ^= col_code(i);
  endfunction

  function automatic logic [DW-1:0] fix_of(input logic [DW-1:0] d, input logic [CW-1:0] s);
    fix_of = d;
    for (int i = 0; i < DW; i++)
      if (s == col_code(i)) fix_of[i] = ~d[i];
  endfunction

  logic [NB*DW-1:0] dec_data;
  logic [NB*CW-1:0] dec_syn;
  logic [NB-1:0]    dec_sgl, dec_dbl;
  logic             mask_q;

  assign gen_chk = chk_of(gen_data);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] raw;
    logic [CW-1:0] s;
    logic          odd, heavy;
    assign raw   = fuse_data[b*DW +: DW];
    assign s     = chk_of(raw) ^ fuse_chk[b*CW +: CW];
    assign odd   = ^s;
    assign heavy = $countones(s) > 3;
    assign dec_data[b*DW +: DW] = ecc_en[b] ? fix_of(raw, s) : raw;
    assign dec_syn[b*CW +: CW]  = ecc_en[b] ? s : '0;
    assign dec_sgl[b] = ecc_en[b] & odd & ~heavy;
    assign dec_dbl[b] = ecc_en[b] & (s != '0) & ~(odd & ~heavy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      syn     <= '0;
      se_flag <= '0;
      de_flag <= '0;
      mask_q  <= 1'b1;
    end else begin
      if (load) begin
        dout <= dec_data;
        syn  <= dec_syn;
      end
      se_flag <= (se_flag & ~clr_se) | (load ? dec_sgl : '0);
      de_flag <= (de_flag & ~clr_de) | (load ? dec_dbl : '0);
      if (irq_mask_we) mask_q <= irq_mask_d;
    end
  end

  assign irq = (|(se_flag | de_flag)) & ~mask_q;

endmodule

// File: rtl/fuse_secded_dec_chk.sv
module fuse_secded_dec_chk #(
  parameter int NB = 10,
  parameter int DW = 20,
  parameter int CW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [NB-1:0]    ecc_en,
  input logic [NB*DW-1:0] fuse_data,
  input logic [NB-1:0]    clr_se,
  input logic [NB*DW-1:0] dout,
  input logic [NB*CW-1:0] syn,
  input logic [NB-1:0]    se_flag,
  input logic [NB-1:0]    de_flag,
  input logic             irq
);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|se_flag) |=> ((($past(se_flag) & ~$past(clr_se)) & ~se_flag) == '0));

  // R2
  flag_set_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((se_flag & ~$past(se_flag)) == '0));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(se_flag | de_flag)));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    // R7
    bypass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !ecc_en[b]) |=> (dout[b*DW +: DW] == $past(fuse_data[b*DW +: DW]) && syn[b*CW +: CW] == '0));
    // R3
    syn_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && ecc_en[b]) |=> (syn[b*CW +: CW] == '0 || se_flag[b] || de_flag[b]));
  end

endmodule

bind fuse_secded_dec fuse_secded_dec_chk #(.NB(NB), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .ecc_en(ecc_en), .fuse_data(fuse_data),
  .clr_se(clr_se), .dout(dout), .syn(syn), .se_flag(se_flag), .de_flag(de_flag), .irq(irq)
);

// File: tb/fuse_secded_dec_tb.sv
`timescale 1ns/1ps
module fuse_secded_dec_tb;
  localparam int NB = 10, DW = 20, CW = 6;

  logic clk = 0, rst_n = 0, load = 0, irq_mask_we = 0, irq_mask_d = 1;
  logic [NB-1:0] ecc_en = '0, clr_se = '0, clr_de = '0;
  logic [NB*DW-1:0] fuse_data = '0;
  logic [NB*CW-1:0] fuse_chk = '0;
  logic [DW-1:0] gen_data = '0;
  logic [CW-1:0] gen_chk;
  logic [NB*DW-1:0] dout;
  logic [NB*CW-1:0] syn;
  logic [NB-1:0] se_flag, de_flag;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fuse_secded_dec #(.NB(NB), .DW(DW), .CW(CW)) u_dut (.*);

  typedef struct packed {
    logic [3:0]  bank;
    logic        en;
    logic [19:0] data;
    logic [25:0] flip;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0, 1'b1, 20'hA5A5A, 26'h0},
    '{4'd3, 1'b1, 20'h12345, 26'h20},
    '{4'd9, 1'b1, 20'hFFFFF, 26'h80000},
    '{4'd1, 1'b1, 20'h00000, 26'h400000},
    '{4'd5, 1'b1, 20'h5A5A5, 26'h81},
    '{4'd2, 1'b1, 20'h0F0F0, 26'h200008},
    '{4'd7, 1'b0, 20'h33333, 26'h400},
    '{4'd4, 1'b0, 20'hC3C3C, 26'h2000201}
  };

  function automatic logic [5:0] tcol(input int k);
    int n = 0;
    tcol = '0;
    for (int v = 0; v < 64; v++)
      if ($countones(v[5:0]) == 3) begin
        if (n == k) tcol = v[5:0];
        n++;
      end
  endfunction

  function automatic logic [5:0] tchk(input logic [19:0] d);
    tchk = '0;
    for (int i = 0; i < 20; i++) if (d[i]) tchk ^= tcol(i);
  endfunction

  function automatic logic [5:0] tsyn(input logic [25:0] f);
    tsyn = '0;
    for (int i = 0; i < 20; i++) if (f[i]) tsyn ^= tcol(i);
    for (int j = 0; j < 6; j++) if (f[20+j]) tsyn ^= 6'(1 << j);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_load();
    @(negedge clk) load = 1;
    @(negedge clk) load = 0;
  endtask

  task automatic clear_all();
    @(negedge clk) begin clr_se = '1; clr_de = '1; end
    @(negedge clk) begin clr_se = '0; clr_de = '0; end
  endtask

  task automatic set_bank(input int b, input logic en, input logic [19:0] d, input logic [25:0] f);
    fuse_data[b*DW +: DW] = d ^ f[19:0];
    fuse_chk[b*CW +: CW]  = tchk(d) ^ f[25:20];
    ecc_en[b] = en;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 dout", dout[31:0], 32'h0);
    chk("R10 flags", {se_flag, de_flag, irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R1 generator
    gen_data = 20'h00020; #1 chk("R1 bit5", gen_chk, 6'h15);
    gen_data = 20'h00001; #1 chk("R1 bit0", gen_chk, 6'h07);
    gen_data = 20'hFFFFF; #1 chk("R1 all", gen_chk, 6'h00);
    gen_data = 20'h80000; #1 chk("R1 bit19", gen_chk, tcol(19));

    // table: R3..R7
    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      int b = int'(v.bank);
      int nf = $countones(v.flip);
      logic [19:0] ed;
      logic [5:0] es;
      logic ese, ede;
      clear_all();
      set_bank(b, v.en, v.data, v.flip);
      pulse_load();
      if (!v.en) begin ed = v.data ^ v.flip[19:0]; es = 0; ese = 0; ede = 0; end
      else begin
        es = tsyn(v.flip);
        ese = (nf == 1); ede = (nf == 2);
        ed = (nf == 2) ? (v.data ^ v.flip[19:0]) : v.data;
      end
      chk($sformatf("R3-7 vec%0d data", k), dout[b*DW +: DW], ed);
      chk($sformatf("R4 vec%0d syn", k), syn[b*CW +: CW], es);
      chk($sformatf("R5 vec%0d se", k), se_flag, ese ? (1 << b) : 0);
      chk($sformatf("R6 vec%0d de", k), de_flag, ede ? (1 << b) : 0);
      set_bank(b, 1'b0, 20'h0, 26'h0);
    end

    // R4 exact code for bit 5
    clear_all();
    set_bank(6, 1'b1, 20'h0, 26'h20);
    pulse_load();
    chk("R4 syn 0x15", syn[6*CW +: CW], 6'h15);
    chk("R4 corrected", dout[6*DW +: DW], 20'h0);

    // R9 masked by default, then unmasked
    chk("R9 masked", irq, 1'b0);
    @(negedge clk) begin irq_mask_we = 1; irq_mask_d = 0; end
    @(negedge clk) irq_mask_we = 0;
    chk("R9 unmasked", irq, 1'b1);

    // R2 inputs change without load: outputs hold
    set_bank(6, 1'b1, 20'h0, 26'h0);
    @(negedge clk);
    chk("R2 hold syn", syn[6*CW +: CW], 6'h15);

    // R8 sticky across clean load, de clear leaves se
    pulse_load();
    chk("R8 sticky", se_flag, 10'h040);
    @(negedge clk) clr_de = '1;
    @(negedge clk) clr_de = '0;
    chk("R8 de clear keeps se", se_flag, 10'h040);
    @(negedge clk) clr_se = 10'h040;
    @(negedge clk) clr_se = '0;
    chk("R8 cleared", se_flag, 10'h000);
    chk("R9 irq low", irq, 1'b0);

    // R8 set wins over clear
    set_bank(8, 1'b1, 20'h0, 26'h1);
    @(negedge clk) begin load = 1; clr_se = 10'h100; end
    @(negedge clk) begin load = 0; clr_se = '0; end
    chk("R8 set wins", se_flag, 10'h100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule